// File: doc/BRIEF.md
# Receive XON/XOFF Flow-Control Detector

This block sits between a UART receiver and its receive FIFO. It looks at every character the receiver completes and compares it with four programmable flow-control values: two for "stop sending" and two for "resume". A stop match raises a request to suspend the local transmitter. The transmitter picks up that request only between characters, so a character already on the line is never cut short. A resume match withdraws the request and clears the detect flag.

The block has two flow-control modes. In single mode one character forms a match. In double mode two back-to-back characters form it. Characters used up as flow control are kept out of the FIFO. In double mode, a held first character that does not complete its pair is passed on to the FIFO in its original order.

A special-character mode replaces flow control. In this mode each character is compared with the second stop value, and every character is stored. A match only sets the detect flag. In all modes the comparison is limited to the programmed word length of 5 to 8 bits.

Top module: `rx_flow_detect`

## Requirements
- R1: After reset, tx_suspend, detect_flag, irq and fifo_we are all low and no first character is held.
- R2: With fc_mode = 2'b01 (single), a character that matches stop1 requests suspension and one that matches go1 requests resume. Neither is written to the FIFO. If a character matches both, stop1 wins. Every other character is written: fifo_we is high with fifo_data equal to the character in the cycle after the clock edge that samples rx_valid.
- R3: tx_suspend changes only at a clock edge where tx_boundary is high, and then it takes the newest request. If tx_boundary is high at the edge that samples the matching character, tx_suspend changes at that same edge.
- R4: A resume match clears the suspension request and clears detect_flag.
- R5: word_len values 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. Only bits [4+word_len:0] take part in every comparison. The FIFO always receives all 8 bits of the character.
- R6: With fc_mode = 2'b10 (double), stop1 followed directly by stop2 requests suspension, and go1 followed directly by go2 requests resume. Neither character of a completed pair is written. A stop2 or go2 character with no held first character is written normally.
- R7: In double mode, if a held first character is followed by a character that does not complete the pair, the held character is written first. The new character is then judged again as a possible first character. If it is not a first character, it is written one cycle after the held one.
- R8: A stop match sets detect_flag only while xoff_irq_en is 1. irq equals detect_flag AND xoff_irq_en.
- R9: With fc_mode = 2'b11 (special), every character is written. A match with stop2 sets detect_flag whatever xoff_irq_en is, and tx_suspend does not change.
- R10: With fc_mode = 2'b00 (off), every character is written, and tx_suspend and detect_flag do not change.
- R11: rx_valid is a single-cycle strobe with at least one idle cycle between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: rx_char holds a completed character |
| rx_char | input | 8 | Received character, bit 0 is the first bit received |
| word_len | input | 2 | Character length: 0..3 selects 5..8 bits |
| fc_mode | input | 2 | 00 off, 01 single, 10 double, 11 special character |
| go1 | input | 8 | First (or only) resume character |
| go2 | input | 8 | Second resume character for double mode |
| stop1 | input | 8 | First (or only) suspend character |
| stop2 | input | 8 | Second suspend character, and the special-mode compare value |
| xoff_irq_en | input | 1 | Enables detect_flag and irq on a stop match |
| tx_boundary | input | 1 | High when the transmitter is between characters |
| tx_suspend | output | 1 | Transmitter must not start a new character while high |
| fifo_we | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | 8 | Character to write into the FIFO |
| detect_flag | output | 1 | Flow-control or special character detected |
| irq | output | 1 | Interrupt request |

## Verification
Each FIFO write shows up in the cycle after the edge that samples rx_valid. The one exception is the character that follows a broken pair, which shows up one cycle later. detect_flag changes at the sampling edge. tx_suspend also changes at that edge when tx_boundary is high; otherwise it changes at the first later edge where tx_boundary is high. The bench therefore drives on falling edges and logs every write at the falling edges. It checks the write log, tx_suspend and the flags three falling edges after each strobe, by which point every result is due. The boundary test also checks tx_suspend on each falling edge while tx_boundary is held low. The word-length and special-mode sweeps cover all 256 character values, with the expected match worked out by masking in the bench.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
   typedef enum logic [1:0] {
      FC_OFF     = 2'b00,
      FC_SINGLE  = 2'b01,
      FC_DOUBLE  = 2'b10,
      FC_SPECIAL = 2'b11
   } fc_mode_e;

   typedef enum logic [1:0] {
      PEND_NONE = 2'b00,
      PEND_STOP = 2'b01,
      PEND_GO   = 2'b10
   } pend_e;

   // comparator slot order
   localparam int SLOT_GO1   = 0;
   localparam int SLOT_GO2   = 1;
   localparam int SLOT_STOP1 = 2;
   localparam int SLOT_STOP2 = 3;
   localparam int N_SLOTS    = 4;
endpackage

// File: rtl/rxfc_char_cmp.sv
module rxfc_char_cmp #(
   parameter int DATA_W = 8,
   parameter int MIN_W  = 5,
   parameter int WL_W   = 2,
   parameter int N_REF  = 4
) (
   input  logic [DATA_W-1:0]       rx_char,
   input  logic [WL_W-1:0]         word_len,
   input  logic [N_REF*DATA_W-1:0] refs,
   output logic [N_REF-1:0]        hit
);
   localparam int MAX_LEN = MIN_W + (1 << WL_W) - 1;

   if (MAX_LEN > DATA_W) begin : g_bad_len
      $error("rxfc_char_cmp: longest word exceeds DATA_W");
   end

   logic [DATA_W-1:0] len_mask;

   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         len_mask[i] = (i < (MIN_W + int'(word_len)));
      end
   end

   for (genvar k = 0; k < N_REF; k++) begin : g_slot
      assign hit[k] = ~|((rx_char ^ refs[k*DATA_W +: DATA_W]) & len_mask);
   end
endmodule

// File: rtl/rxfc_pair_tracker.sv
module rxfc_pair_tracker
   import rxfc_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit DOUBLE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_char,
   input  fc_mode_e          mode,
   input  logic              hit_go1,
   input  logic              hit_go2,
   input  logic              hit_stop1,
   input  logic              hit_stop2,
   output logic              stop_evt,
   output logic              go_evt,
   output logic              spec_evt,
   output logic              fifo_we,
   output logic [DATA_W-1:0] fifo_data
);
   pend_e             pend_q, pend_n;
   logic [DATA_W-1:0] held_q, held_n;
   logic              spill_vld, spill_set;
   logic [DATA_W-1:0] spill_q;
   logic              wr_now, new_free, as_single;
   logic [DATA_W-1:0] wr_data;

   assign as_single = (mode == FC_SINGLE) || ((mode == FC_DOUBLE) && !DOUBLE_EN);

   always_comb begin
      stop_evt  = 1'b0;
      go_evt    = 1'b0;
      spec_evt  = 1'b0;
      wr_now    = 1'b0;
      wr_data   = rx_char;
      spill_set = 1'b0;
      new_free  = 1'b1;
      pend_n    = pend_q;
      held_n    = held_q;
      if (rx_valid) begin
         if (as_single) begin
            pend_n = PEND_NONE;
            if (hit_stop1)    stop_evt = 1'b1;
            else if (hit_go1) go_evt   = 1'b1;
            else              wr_now   = 1'b1;
         end else if (mode == FC_DOUBLE) begin
            if (pend_q == PEND_STOP && hit_stop2) begin
               stop_evt = 1'b1;
               pend_n   = PEND_NONE;
            end else if (pend_q == PEND_GO && hit_go2) begin
               go_evt = 1'b1;
               pend_n = PEND_NONE;
            end else begin
               if (hit_stop1) begin
                  pend_n   = PEND_STOP;
                  held_n   = rx_char;
                  new_free = 1'b0;
               end else if (hit_go1) begin
                  pend_n   = PEND_GO;
                  held_n   = rx_char;
                  new_free = 1'b0;
               end else begin
                  pend_n = PEND_NONE;
               end
               if (pend_q != PEND_NONE) begin
                  wr_now    = 1'b1;
                  wr_data   = held_q;
                  spill_set = new_free;
               end else begin
                  wr_now = new_free;
               end
            end
         end else if (mode == FC_SPECIAL) begin
            pend_n   = PEND_NONE;
            wr_now   = 1'b1;
            spec_evt = hit_stop2;
         end else begin
            pend_n = PEND_NONE;
            wr_now = 1'b1;
         end
      end
   end

   if (DOUBLE_EN) begin : g_pair
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q <= PEND_NONE;
            held_q <= '0;
         end else begin
            pend_q <= pend_n;
            held_q <= held_n;
         end
      end
   end else begin : g_no_pair
      assign pend_q = PEND_NONE;
      assign held_q = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fifo_we   <= 1'b0;
         fifo_data <= '0;
         spill_vld <= 1'b0;
         spill_q   <= '0;
      end else begin
         fifo_we   <= wr_now | spill_vld;
         fifo_data <= spill_vld ? spill_q : wr_data;
         spill_vld <= spill_set;
         spill_q   <= rx_char;
      end
   end

   // R2: a single-mode flow-control character never reaches the FIFO
   assert_drop_single_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && mode == FC_SINGLE && (hit_stop1 || hit_go1) && !spill_vld) |=> !fifo_we);

   // R9: special-mode match is stored unchanged
   assert_special_store_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && mode == FC_SPECIAL && hit_stop2 && !spill_vld)
      |=> (fifo_we && fifo_data == $past(rx_char)));

   // R11: strobes are separated by an idle cycle
   assert_strobe_gap_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
endmodule

// File: rtl/rxfc_suspend_ctl.sv
module rxfc_suspend_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_evt,
   input  logic go_evt,
   input  logic spec_evt,
   input  logic irq_en,
   input  logic tx_boundary,
   output logic tx_suspend,
   output logic detect_flag
);
   logic req_q, req_n;

   always_comb begin
      req_n = req_q;
      if (stop_evt)    req_n = 1'b1;
      else if (go_evt) req_n = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q       <= 1'b0;
         tx_suspend  <= 1'b0;
         detect_flag <= 1'b0;
      end else begin
         req_q <= req_n;
         if (tx_boundary) tx_suspend <= req_n;
         if (go_evt)
            detect_flag <= 1'b0;
         else if ((stop_evt && irq_en) || spec_evt)
            detect_flag <= 1'b1;
      end
   end

   // R3: no change to the suspend output in mid-character
   assert_hold_mid_char_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !tx_boundary |=> $stable(tx_suspend));

   // R4: a resume match clears the flag
   assert_resume_clears_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      go_evt |=> !detect_flag);

   // R8: stop match with interrupts disabled leaves the flag low
   assert_flag_gated_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && !irq_en && !spec_evt && !detect_flag) |=> !detect_flag);
endmodule

// File: rtl/rx_flow_detect.sv
module rx_flow_detect
   import rxfc_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int MIN_W     = 5,
   parameter int WL_W      = 2,
   parameter bit DOUBLE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_char,
   input  logic [WL_W-1:0]   word_len,
   input  logic [1:0]        fc_mode,
   input  logic [DATA_W-1:0] go1,
   input  logic [DATA_W-1:0] go2,
   input  logic [DATA_W-1:0] stop1,
   input  logic [DATA_W-1:0] stop2,
   input  logic              xoff_irq_en,
   input  logic              tx_boundary,
   output logic              tx_suspend,
   output logic              fifo_we,
   output logic [DATA_W-1:0] fifo_data,
   output logic              detect_flag,
   output logic              irq
);
   localparam int MAX_LEN = MIN_W + (1 << WL_W) - 1;

   if (MIN_W < 1 || MAX_LEN > DATA_W) begin : g_bad_cfg
      $error("rx_flow_detect: MIN_W/WL_W do not fit DATA_W");
   end

   logic [N_SLOTS*DATA_W-1:0] refs;
   logic [N_SLOTS-1:0]        hit;
   logic                      stop_evt, go_evt, spec_evt;
   fc_mode_e                  mode;

   assign mode = fc_mode_e'(fc_mode);
   assign refs = {stop2, stop1, go2, go1};

   rxfc_char_cmp #(
      .DATA_W (DATA_W),
      .MIN_W  (MIN_W),
      .WL_W   (WL_W),
      .N_REF  (N_SLOTS)
   ) cmp_i (
      .rx_char  (rx_char),
      .word_len (word_len),
      .refs     (refs),
      .hit      (hit)
   );

   rxfc_pair_tracker #(
      .DATA_W    (DATA_W),
      .DOUBLE_EN (DOUBLE_EN)
   ) trk_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_char   (rx_char),
      .mode      (mode),
      .hit_go1   (hit[SLOT_GO1]),
      .hit_go2   (hit[SLOT_GO2]),
      .hit_stop1 (hit[SLOT_STOP1]),
      .hit_stop2 (hit[SLOT_STOP2]),
      .stop_evt  (stop_evt),
      .go_evt    (go_evt),
      .spec_evt  (spec_evt),
      .fifo_we   (fifo_we),
      .fifo_data (fifo_data)
   );

   rxfc_suspend_ctl sus_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .stop_evt    (stop_evt),
      .go_evt      (go_evt),
      .spec_evt    (spec_evt),
      .irq_en      (xoff_irq_en),
      .tx_boundary (tx_boundary),
      .tx_suspend  (tx_suspend),
      .detect_flag (detect_flag)
   );

   assign irq = detect_flag & xoff_irq_en;

   // R10: off mode never touches suspend or flag
   assert_off_quiet_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && mode == FC_OFF) |=> ($stable(detect_flag) && $stable(tx_suspend)));
endmodule

// File: tb/rx_flow_detect_tb_top.sv
module rx_flow_detect_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       rx_valid;
   logic [7:0] rx_char;
   logic [1:0] word_len;
   logic [1:0] fc_mode;
   logic [7:0] go1, go2, stop1, stop2;
   logic       xoff_irq_en;
   logic       tx_boundary;
   logic       tx_suspend, fifo_we, detect_flag, irq;
   logic [7:0] fifo_data;

   int n_chk  = 0;
   int n_fail = 0;
   int nw     = 0;
   logic [7:0] got [8];
   bit   done = 1'b0;

   always #10 clk = ~clk;

   rx_flow_detect dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
      .word_len(word_len), .fc_mode(fc_mode), .go1(go1), .go2(go2),
      .stop1(stop1), .stop2(stop2), .xoff_irq_en(xoff_irq_en),
      .tx_boundary(tx_boundary), .tx_suspend(tx_suspend), .fifo_we(fifo_we),
      .fifo_data(fifo_data), .detect_flag(detect_flag), .irq(irq)
   );

   always @(negedge clk) begin
      if (fifo_we) begin
         if (nw < 8) got[nw] = fifo_data;
         nw++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      rx_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send(input logic [7:0] c);
      nw = 0;
      @(negedge clk);
      rx_char  = c;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   function automatic bit mhit(input logic [7:0] a, input logic [7:0] b, input int wl);
      int m = (1 << (5 + wl)) - 1;
      return ((int'(a ^ b) & m) == 0);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      bit exp_s, exp_f;
      rx_char = 8'h00; word_len = 2'd3; fc_mode = 2'b00;
      go1 = 8'h00; go2 = 8'h00; stop1 = 8'h00; stop2 = 8'h00;
      xoff_irq_en = 1'b1; tx_boundary = 1'b1;
      do_reset();

      // R1 reset state
      chk(tx_suspend == 0, "R1 tx_suspend", tx_suspend, 0);
      chk(detect_flag == 0, "R1 detect_flag", detect_flag, 0);
      chk(irq == 0, "R1 irq", irq, 0);
      chk(fifo_we == 0, "R1 fifo_we", fifo_we, 0);

      // R10 off mode: everything stored
      stop1 = 8'hD3; go1 = 8'h5A; stop2 = 8'h7E; go2 = 8'h19;
      send(8'hD3);
      chk(nw == 1 && got[0] == 8'hD3, "R10 off mode store", got[0], 8'hD3);
      chk(tx_suspend == 0 && detect_flag == 0, "R10 off mode quiet", tx_suspend, 0);

      // R2/R4/R5 single mode sweep over word lengths and all characters
      fc_mode = 2'b01;
      for (int wl = 0; wl < 4; wl++) begin
         do_reset();
         word_len = wl[1:0];
         exp_s = 0;
         for (int c = 0; c < 256; c++) begin
            bit hs, hg;
            hs = mhit(c[7:0], stop1, wl);
            hg = mhit(c[7:0], go1, wl);
            send(c[7:0]);
            if (hs) exp_s = 1;
            else if (hg) exp_s = 0;
            if (hs || hg)
               chk(nw == 0, "R2 R5 flow char dropped", nw, 0);
            else
               chk(nw == 1 && got[0] == c[7:0], "R2 R5 data stored", got[0], c);
            chk(tx_suspend == exp_s, "R2 R3 suspend", tx_suspend, exp_s);
            chk(detect_flag == exp_s, "R4 R8 flag", detect_flag, exp_s);
         end
      end

      // R3 suspend waits for a character boundary
      do_reset();
      word_len = 2'd3;
      tx_boundary = 1'b0;
      send(8'hD3);
      for (int i = 0; i < 4; i++) begin
         chk(tx_suspend == 0, "R3 held mid character", tx_suspend, 0);
         @(negedge clk);
      end
      tx_boundary = 1'b1;
      @(negedge clk);
      chk(tx_suspend == 1, "R3 applied at boundary", tx_suspend, 1);

      // R8 flag gated by the enable
      do_reset();
      xoff_irq_en = 1'b0;
      send(8'hD3);
      chk(tx_suspend == 1, "R8 suspend without enable", tx_suspend, 1);
      chk(detect_flag == 0 && irq == 0, "R8 flag stays low", detect_flag, 0);
      send(8'h5A);
      xoff_irq_en = 1'b1;
      send(8'hD3);
      chk(detect_flag == 1 && irq == 1, "R8 flag and irq raised", irq, 1);
      @(negedge clk);
      xoff_irq_en = 1'b0;
      #1;
      chk(irq == 0 && detect_flag == 1, "R8 irq masked", irq, 0);
      xoff_irq_en = 1'b1;

      // R6/R7 double mode
      do_reset();
      fc_mode = 2'b10;
      stop1 = 8'h13; stop2 = 8'h17; go1 = 8'h11; go2 = 8'h19;
      send(8'h17);
      chk(nw == 1 && got[0] == 8'h17, "R6 lone second char stored", got[0], 8'h17);
      send(8'h13);
      chk(nw == 0, "R6 first char held", nw, 0);
      send(8'h41);
      chk(nw == 2 && got[0] == 8'h13 && got[1] == 8'h41, "R7 broken pair order",
          {got[0], got[1]}, 16'h1341);
      chk(tx_suspend == 0, "R7 no suspend on broken pair", tx_suspend, 0);
      send(8'h13);
      send(8'h13);
      chk(nw == 1 && got[0] == 8'h13, "R7 re-evaluated first char", got[0], 8'h13);
      send(8'h17);
      chk(nw == 0, "R6 stop pair dropped", nw, 0);
      chk(tx_suspend == 1 && detect_flag == 1, "R6 stop pair suspends", tx_suspend, 1);
      send(8'h11);
      send(8'h19);
      chk(nw == 0, "R6 go pair dropped", nw, 0);
      chk(tx_suspend == 0 && detect_flag == 0, "R6 R4 go pair resumes", tx_suspend, 0);
      send(8'h11);
      send(8'h13);
      chk(nw == 1 && got[0] == 8'h11, "R7 held go char flushed", got[0], 8'h11);
      send(8'h17);
      chk(tx_suspend == 1, "R7 pair after flush suspends", tx_suspend, 1);

      // R9 special mode sweep
      do_reset();
      fc_mode = 2'b11;
      xoff_irq_en = 1'b0;
      word_len = 2'd2;
      exp_f = 0;
      for (int c = 0; c < 256; c++) begin
         send(c[7:0]);
         if (mhit(c[7:0], stop2, 2)) exp_f = 1;
         chk(nw == 1 && got[0] == c[7:0], "R9 special stores all", got[0], c);
         chk(detect_flag == exp_f, "R9 special flag", detect_flag, exp_f);
         chk(tx_suspend == 0, "R9 no suspend", tx_suspend, 0);
      end

      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule